// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit works out where an instruction's operand lives for an 8-bit processor with a 16-bit address space. On a `start` pulse it captures the addressing mode, the program counter and the two index registers. It then fetches the operand bytes and any pointer bytes through a byte-wide read port. That port is meant to feed a synchronous single-port memory with one cycle of read latency. When it is finished, it presents the resulting 16-bit address together with a one-cycle `done_o` strobe.

Several kinds of mode are supported:

- Immediate and no-operand modes complete without touching memory.
- Zero-page modes fetch one byte and stay inside the first 256 bytes, even when indexed.
- Absolute modes assemble a little-endian word and may add an index register across the full 16-bit range.
- The two indirect forms fetch a two-byte pointer from page zero. One form indexes before the pointer fetch and the other after it.

A decoder drives `mode_i` and pulses `start_i`. The result on `ea_o` then stays put until the next completed request, so the consumer may read it at any later time.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted, `done_o` is 0, `mem_rd_en_o` is 0 and `ea_o` is 0x0000.
- R2: Mode 1 (immediate) makes no memory read and returns the captured program counter, with `done_o` high in the cycle after the accepting clock edge.
- R3: Mode 0 (no operand) and the unused codes 10 to 15 make no memory read and return 0x0000, with `done_o` high in the cycle after the accepting edge.
- R4: Mode 2 (zero page) reads one byte at the program counter and returns it zero-extended, with `done_o` high three cycles after the accepting edge.
- R5: Modes 3 and 4 (zero page indexed by X or by Y) return 0x00 in the upper byte and (fetched byte + index) mod 256 in the lower byte.
- R6: Mode 5 (absolute) reads the low byte at PC and the high byte at (PC+1) mod 65536, and returns high*256+low four cycles after the accepting edge.
- R7: Modes 6 and 7 (absolute indexed by X or by Y) return (absolute word + index) mod 65536.
- R8: Mode 8 (pre-indexed indirect) reads base B at PC, then the pointer low byte at (B+X) mod 256 and the pointer high byte at (B+X+1) mod 256, all in page zero. It returns the pointer five cycles after the accepting edge.
- R9: Mode 9 (post-indexed indirect) reads base B at PC, then the pointer bytes at B and (B+1) mod 256 in page zero. It returns (pointer + Y) mod 65536 five cycles after the accepting edge.
- R10: `done_o` is high for exactly one cycle per request, and `ea_o` changes only in a cycle where `done_o` is high.
- R11: A `start_i` pulse while a request is in progress is ignored, and the mode, PC and index values in use are those captured at the accepted start.
- R12: Each request issues exactly as many one-cycle read strobes as it has bytes to fetch (0, 1, 2 or 3), and all of them come before `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| mode_i | input | 4 | Addressing mode code |
| pc_i | input | 16 | Program counter pointing at the operand bytes |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| mem_rd_en_o | output | 1 | Read strobe to memory |
| mem_rd_addr_o | output | 16 | Read address |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the strobe |
| done_o | output | 1 | One-cycle completion strobe |
| ea_o | output | 16 | Effective address, held until the next completion |

## Verification
The latency of a result depends only on how many bytes it needs. Counting the accepting edge as the first, `done_o` rises after edge 1 for immediate and no-operand modes, after edge 3 for zero-page modes, after edge 4 for absolute modes and after edge 5 for the indirect forms. Each directed task raises `start_i` on a falling edge and counts falling edges until the strobe. It then compares that count with the figure for the mode, and samples `ea_o` and the number of read strobes at the same falling edge. One falling edge later it confirms that the strobe has dropped and that the address has held.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int AW     = 16;
    localparam int DW     = 8;
    localparam int MW     = 4;
    localparam int PAGE_W = AW - DW;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;
    typedef logic [MW-1:0] mode_t;

    localparam mode_t AM_NONE = 4'd0;
    localparam mode_t AM_IMM  = 4'd1;
    localparam mode_t AM_ZP   = 4'd2;
    localparam mode_t AM_ZPX  = 4'd3;
    localparam mode_t AM_ZPY  = 4'd4;
    localparam mode_t AM_ABS  = 4'd5;
    localparam mode_t AM_ABSX = 4'd6;
    localparam mode_t AM_ABSY = 4'd7;
    localparam mode_t AM_INDX = 4'd8;
    localparam mode_t AM_INDY = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_B0,
        ST_B1,
        ST_B2
    } st_e;

    typedef struct packed {
        mode_t mode;
        addr_t pc;
        byte_t x;
        byte_t y;
    } ctx_t;

    function automatic addr_t zp_addr(byte_t b);
        return {{PAGE_W{1'b0}}, b};
    endfunction

    function automatic byte_t zp_add(byte_t a, byte_t b);
        return a + b;
    endfunction

    function automatic addr_t word(byte_t hi, byte_t lo);
        return {hi, lo};
    endfunction

    function automatic addr_t idx16(addr_t base, byte_t i);
        return base + zp_addr(i);
    endfunction

    function automatic logic uses_mem(mode_t m);
        return (m >= AM_ZP) && (m <= AM_INDY);
    endfunction

    function automatic logic is_ind(mode_t m);
        return (m == AM_INDX) || (m == AM_INDY);
    endfunction

endpackage

// File: rtl/ea_math.sv
module ea_math
    import ea_pkg::*;
(
    input  st_e   st_i,
    input  logic  start_i,
    input  mode_t mode_i,
    input  addr_t pc_i,
    input  ctx_t  ctx_i,
    input  byte_t lo_i,
    input  byte_t zb_i,
    input  byte_t rd_data_i,
    output st_e   st_nxt_o,
    output logic  rd_en_o,
    output addr_t rd_addr_o,
    output logic  fin_o,
    output addr_t ea_nxt_o,
    output logic  lo_we_o,
    output logic  zb_we_o,
    output byte_t zb_nxt_o
);

    byte_t sum_x;
    byte_t sum_y;
    byte_t zb_inc;
    addr_t fetched_word;

    assign sum_x        = zp_add(rd_data_i, ctx_i.x);
    assign sum_y        = zp_add(rd_data_i, ctx_i.y);
    assign zb_inc       = zp_add(zb_i, byte_t'(1));
    assign fetched_word = word(rd_data_i, lo_i);

    always_comb begin
        st_nxt_o  = st_i;
        rd_en_o   = 1'b0;
        rd_addr_o = '0;
        fin_o     = 1'b0;
        ea_nxt_o  = '0;
        lo_we_o   = 1'b0;
        zb_we_o   = 1'b0;
        zb_nxt_o  = '0;
        case (st_i)
            ST_IDLE: begin
                if (start_i) begin
                    if (uses_mem(mode_i)) begin
                        st_nxt_o = ST_ISSUE;
                    end else begin
                        fin_o    = 1'b1;
                        ea_nxt_o = (mode_i == AM_IMM) ? pc_i : '0;
                    end
                end
            end
            ST_ISSUE: begin
                rd_en_o   = 1'b1;
                rd_addr_o = ctx_i.pc;
                st_nxt_o  = ST_B0;
            end
            ST_B0: begin
                case (ctx_i.mode)
                    AM_ZP: begin
                        fin_o    = 1'b1;
                        ea_nxt_o = zp_addr(rd_data_i);
                        st_nxt_o = ST_IDLE;
                    end
                    AM_ZPX: begin
                        fin_o    = 1'b1;
                        ea_nxt_o = zp_addr(sum_x);
                        st_nxt_o = ST_IDLE;
                    end
                    AM_ZPY: begin
                        fin_o    = 1'b1;
                        ea_nxt_o = zp_addr(sum_y);
                        st_nxt_o = ST_IDLE;
                    end
                    AM_INDX: begin
                        zb_we_o   = 1'b1;
                        zb_nxt_o  = sum_x;
                        rd_en_o   = 1'b1;
                        rd_addr_o = zp_addr(sum_x);
                        st_nxt_o  = ST_B1;
                    end
                    AM_INDY: begin
                        zb_we_o   = 1'b1;
                        zb_nxt_o  = rd_data_i;
                        rd_en_o   = 1'b1;
                        rd_addr_o = zp_addr(rd_data_i);
                        st_nxt_o  = ST_B1;
                    end
                    default: begin
                        lo_we_o   = 1'b1;
                        rd_en_o   = 1'b1;
                        rd_addr_o = ctx_i.pc + addr_t'(1);
                        st_nxt_o  = ST_B1;
                    end
                endcase
            end
            ST_B1: begin
                if (is_ind(ctx_i.mode)) begin
                    lo_we_o   = 1'b1;
                    rd_en_o   = 1'b1;
                    rd_addr_o = zp_addr(zb_inc);
                    st_nxt_o  = ST_B2;
                end else begin
                    fin_o    = 1'b1;
                    st_nxt_o = ST_IDLE;
                    case (ctx_i.mode)
                        AM_ABSX: ea_nxt_o = idx16(fetched_word, ctx_i.x);
                        AM_ABSY: ea_nxt_o = idx16(fetched_word, ctx_i.y);
                        default: ea_nxt_o = fetched_word;
                    endcase
                end
            end
            ST_B2: begin
                fin_o    = 1'b1;
                st_nxt_o = ST_IDLE;
                ea_nxt_o = (ctx_i.mode == AM_INDY) ? idx16(fetched_word, ctx_i.y)
                                                   : fetched_word;
            end
            default: st_nxt_o = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  mode_t mode_i,
    input  addr_t pc_i,
    input  byte_t x_i,
    input  byte_t y_i,
    input  st_e   st_nxt_i,
    input  logic  fin_i,
    input  addr_t ea_nxt_i,
    input  logic  lo_we_i,
    input  logic  zb_we_i,
    input  byte_t zb_nxt_i,
    input  byte_t rd_data_i,
    output st_e   st_o,
    output ctx_t  ctx_o,
    output byte_t lo_o,
    output byte_t zb_o,
    output addr_t ea_o,
    output logic  done_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_o   <= ST_IDLE;
            ctx_o  <= '0;
            lo_o   <= '0;
            zb_o   <= '0;
            ea_o   <= '0;
            done_o <= 1'b0;
        end else begin
            st_o   <= st_nxt_i;
            done_o <= fin_i;
            if (fin_i) begin
                ea_o <= ea_nxt_i;
            end
            if ((st_o == ST_IDLE) && start_i) begin
                ctx_o.mode <= mode_i;
                ctx_o.pc   <= pc_i;
                ctx_o.x    <= x_i;
                ctx_o.y    <= y_i;
            end
            if (lo_we_i) begin
                lo_o <= rd_data_i;
            end
            if (zb_we_i) begin
                zb_o <= zb_nxt_i;
            end
        end
    end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [3:0]  mode_i,
    input  logic [15:0] pc_i,
    input  logic [7:0]  x_i,
    input  logic [7:0]  y_i,
    output logic        mem_rd_en_o,
    output logic [15:0] mem_rd_addr_o,
    input  logic [7:0]  mem_rd_data_i,
    output logic        done_o,
    output logic [15:0] ea_o
);

    st_e   st_q;
    st_e   st_nxt;
    ctx_t  ctx_q;
    byte_t lo_q;
    byte_t zb_q;
    logic  fin;
    addr_t ea_nxt;
    logic  lo_we;
    logic  zb_we;
    byte_t zb_nxt;

    ea_math u_math (
        .st_i      (st_q),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .pc_i      (pc_i),
        .ctx_i     (ctx_q),
        .lo_i      (lo_q),
        .zb_i      (zb_q),
        .rd_data_i (mem_rd_data_i),
        .st_nxt_o  (st_nxt),
        .rd_en_o   (mem_rd_en_o),
        .rd_addr_o (mem_rd_addr_o),
        .fin_o     (fin),
        .ea_nxt_o  (ea_nxt),
        .lo_we_o   (lo_we),
        .zb_we_o   (zb_we),
        .zb_nxt_o  (zb_nxt)
    );

    ea_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .pc_i      (pc_i),
        .x_i       (x_i),
        .y_i       (y_i),
        .st_nxt_i  (st_nxt),
        .fin_i     (fin),
        .ea_nxt_i  (ea_nxt),
        .lo_we_i   (lo_we),
        .zb_we_i   (zb_we),
        .zb_nxt_i  (zb_nxt),
        .rd_data_i (mem_rd_data_i),
        .st_o      (st_q),
        .ctx_o     (ctx_q),
        .lo_o      (lo_q),
        .zb_o      (zb_q),
        .ea_o      (ea_o),
        .done_o    (done_o)
    );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
    import ea_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  done,
    input addr_t ea,
    input logic  rd_en,
    input addr_t rd_addr,
    input st_e   st,
    input mode_t mode_q,
    input addr_t pc_q
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!done && !rd_en && ea == '0));

    p_imm_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q == AM_IMM) |-> (ea == pc_q));

    p_none_noread_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !uses_mem(mode_q) && mode_q != AM_IMM) |-> (ea == '0 && $past(!rd_en)));

    p_zp_page0_r5: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
        |-> (ea[AW-1:DW] == '0));

    p_ptr_page0_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && is_ind(mode_q) && st != ST_ISSUE) |-> (rd_addr[AW-1:DW] == '0));

    p_ea_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(ea));

    p_ctx_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> ($stable(mode_q) && $stable(pc_q)));

    p_read_before_done_r12: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !done);

endmodule

bind ea_gen ea_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done_o),
    .ea      (ea_o),
    .rd_en   (mem_rd_en_o),
    .rd_addr (mem_rd_addr_o),
    .st      (st_q),
    .mode_q  (ctx_q.mode),
    .pc_q    (ctx_q.pc)
);

// File: tb/ea_gen_tb.sv
`timescale 1ns/1ps
module ea_gen_tb;
    import ea_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  start = 1'b0;
    mode_t mode = '0;
    addr_t pc = '0;
    byte_t x = '0;
    byte_t y = '0;
    logic  rd_en;
    addr_t rd_addr;
    byte_t rd_data = '0;
    logic  done;
    addr_t ea;

    int n_run = 0;
    int n_fail = 0;
    int rd_total = 0;

    addr_t ov_a [16];
    byte_t ov_d [16];
    int    ov_n = 0;

    always #2.5 clk = ~clk;

    ea_gen u_dut (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .mode_i        (mode),
        .pc_i          (pc),
        .x_i           (x),
        .y_i           (y),
        .mem_rd_en_o   (rd_en),
        .mem_rd_addr_o (rd_addr),
        .mem_rd_data_i (rd_data),
        .done_o        (done),
        .ea_o          (ea)
    );

    function automatic byte_t memf(addr_t a);
        byte_t v = a[7:0] ^ a[15:8] ^ 8'hA5;
        for (int i = 0; i < 16; i++) begin
            if (i < ov_n && ov_a[i] == a) v = ov_d[i];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (rd_en) rd_data <= memf(rd_addr);
        if (!rst && rd_en) rd_total <= rd_total + 1;
    end

    task automatic put(addr_t a, byte_t d);
        ov_a[ov_n] = a;
        ov_d[ov_n] = d;
        ov_n++;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(mode_t m, addr_t p, byte_t xi, byte_t yi,
                          addr_t exp_ea, int exp_lat, int exp_rd, string req);
        int lat;
        int r0;
        @(negedge clk);
        mode = m; pc = p; x = xi; y = yi; start = 1'b1;
        r0 = rd_total;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(done == 1'b1, req, "done", int'(done), 1);
        check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(ea == exp_ea, req, "ea", int'(ea), int'(exp_ea));
        check(rd_total - r0 == exp_rd, "R12", "read count", rd_total - r0, exp_rd);
        @(negedge clk);
        check(done == 1'b0, "R10", "done pulse width", int'(done), 0);
        check(ea == exp_ea, "R10", "ea hold", int'(ea), int'(exp_ea));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(rd_en == 1'b0, "R1", "rd_en in reset", int'(rd_en), 0);
        check(ea == '0, "R1", "ea in reset", int'(ea), 0);
        rst = 1'b0;
    endtask

    task automatic t_imm();
        ov_n = 0;
        run_op(AM_IMM, 16'h1234, 8'h11, 8'h22, 16'h1234, 1, 0, "R2");
    endtask

    task automatic t_none();
        ov_n = 0;
        run_op(AM_NONE, 16'h4444, 8'h01, 8'h02, 16'h0000, 1, 0, "R3");
        run_op(AM_IMM, 16'h7777, 8'h00, 8'h00, 16'h7777, 1, 0, "R2");
        run_op(4'hC, 16'h4444, 8'h01, 8'h02, 16'h0000, 1, 0, "R3");
    endtask

    task automatic t_zp();
        ov_n = 0;
        put(16'h0300, 8'h80);
        run_op(AM_ZP, 16'h0300, 8'h10, 8'h20, 16'h0080, 3, 1, "R4");
    endtask

    task automatic t_zp_idx();
        ov_n = 0;
        put(16'h0310, 8'hF0);
        put(16'h0320, 8'hFE);
        run_op(AM_ZPX, 16'h0310, 8'h20, 8'h99, 16'h0010, 3, 1, "R5");
        run_op(AM_ZPY, 16'h0320, 8'h77, 8'h05, 16'h0003, 3, 1, "R5");
    endtask

    task automatic t_abs();
        ov_n = 0;
        put(16'h8000, 8'h34);
        put(16'h8001, 8'h12);
        put(16'hFFFF, 8'hCD);
        put(16'h0000, 8'hAB);
        run_op(AM_ABS, 16'h8000, 8'h05, 8'h06, 16'h1234, 4, 2, "R6");
        run_op(AM_ABS, 16'hFFFF, 8'h05, 8'h06, 16'hABCD, 4, 2, "R6");
    endtask

    task automatic t_abs_idx();
        ov_n = 0;
        put(16'h9000, 8'hF0);
        put(16'h9001, 8'h12);
        put(16'h9100, 8'hF0);
        put(16'h9101, 8'hFF);
        run_op(AM_ABSX, 16'h9000, 8'h20, 8'h03, 16'h1310, 4, 2, "R7");
        run_op(AM_ABSY, 16'h9100, 8'h03, 8'h20, 16'h0010, 4, 2, "R7");
    endtask

    task automatic t_indx();
        ov_n = 0;
        put(16'hA000, 8'hFE);
        put(16'h00FF, 8'h78);
        put(16'h0000, 8'h56);
        run_op(AM_INDX, 16'hA000, 8'h01, 8'h40, 16'h5678, 5, 3, "R8");
    endtask

    task automatic t_indy();
        ov_n = 0;
        put(16'hA100, 8'hFF);
        put(16'h00FF, 8'hF0);
        put(16'h0000, 8'h12);
        run_op(AM_INDY, 16'hA100, 8'h09, 8'h30, 16'h1320, 5, 3, "R9");
    endtask

    task automatic t_busy();
        int ndone = 0;
        int first = 0;
        addr_t seen = '0;
        ov_n = 0;
        put(16'hB000, 8'h11);
        put(16'hB001, 8'h22);
        @(negedge clk);
        mode = AM_ABS; pc = 16'hB000; x = 8'h00; y = 8'h00; start = 1'b1;
        for (int c = 1; c <= 10; c++) begin
            @(negedge clk);
            if (done) begin
                ndone++;
                if (first == 0) begin
                    first = c;
                    seen  = ea;
                end
            end
            if (c == 1) start = 1'b0;
            if (c == 2) begin
                start = 1'b1; mode = AM_IMM; pc = 16'h5555;
            end
            if (c == 3) begin
                start = 1'b0; pc = 16'hB800;
            end
        end
        check(ndone == 1, "R11", "done count", ndone, 1);
        check(first == 4, "R11", "latency", first, 4);
        check(seen == 16'h2211, "R11", "ea", int'(seen), 16'h2211);
        check(ea == 16'h2211, "R10", "ea after idle", int'(ea), 16'h2211);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_imm();
        t_none();
        t_zp();
        t_zp_idx();
        t_abs();
        t_abs_idx();
        t_indx();
        t_indy();
        t_busy();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule